// File: doc/BRIEF.md
# I2C Baud Factor Search Engine

This block picks the clock divider settings for a two-wire serial bus controller. Given the frequency of the reference clock and the bus frequency wanted, it walks every combination of a 3-bit exponent divider N and a 4-bit linear divider M. For each pair the resulting bus rate is the reference frequency divided by ten, by (M+1) and by 2 to the power (N+1), with the remainder discarded. The engine keeps the pair whose rate comes closest to the request without going over it.

Candidates are evaluated one at a time. A single serial shift-subtract divider is shared by all of them. A search is launched with a one-cycle start pulse. When it ends, the engine reports the chosen N and M, the two of them packed into the 7-bit value the baud register expects, a flag that tells whether any pair fitted, and a one-cycle done strobe. The search stops early once a pair hits the request exactly.

Top module: `baud_search`

## Requirements
- R1: A start pulse sampled while the engine is idle captures the reference and request inputs, and busy_o is high in the following cycle.
- R2: The bus rate of a candidate equals floor(fref / (10 × (M+1) × 2^(N+1))), computed on 32-bit unsigned values.
- R3: Candidates are visited with N as the outer index (0 up to 7) and M as the inner index (0 up to 15). A candidate replaces the current best only when its rate is at most the request and the request minus its rate is strictly below the best difference so far, so on a tie the earlier pair is kept. The best difference starts at all ones on every start.
- R4: The search ends right after the first candidate that leaves a best difference of zero, or else after the last pair (N=7, M=15). done_o rises exactly 34×K clock edges after the edge that sampled start, where K is the number of candidates evaluated.
- R5: done_o is high for exactly one cycle per search, and busy_o is low whenever done_o is high.
- R6: When no candidate rate is at or below the request, found_o is 0 and n_o and m_o are both 0. Otherwise found_o is 1.
- R7: baud_o carries M in bits 6:3 and N in bits 2:0.
- R8: A start pulse while busy_o is high is ignored: neither the results nor the timing of the search in progress change.
- R9: After done_o, the outputs n_o, m_o, baud_o and found_o hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a search |
| fref_i | input | 32 | Reference clock frequency |
| req_i | input | 32 | Requested bus frequency |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle strobe when the search ends |
| found_o | output | 1 | A candidate at or below the request was found |
| n_o | output | 3 | Chosen exponent divider |
| m_o | output | 4 | Chosen linear divider |
| baud_o | output | 7 | Packed divider value, M in 6:3 and N in 2:0 |

## Verification
Every candidate costs 34 cycles: one to launch the divide, 32 shift-subtract steps and one to evaluate. The bench runs its own model of the search to get K, the number of candidates that will be evaluated, and from that knows the result is due exactly 34×K edges after the start edge. It counts edges from the start, samples on falling edges, and flags done_o if it rises early or late. busy_o is checked one cycle after start, done_o one cycle after its pulse, and the held outputs a few idle cycles later while the inputs are moving.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;

    localparam int FREQ_W  = 32;
    localparam int N_W     = 3;
    localparam int M_W     = 4;
    localparam int SCALE   = 10;
    localparam int BAUD_W  = N_W + M_W;

    typedef logic [N_W-1:0]    n_idx_t;
    typedef logic [M_W-1:0]    m_idx_t;
    typedef logic [FREQ_W-1:0] freq_t;

    // N is the upper field so that incrementing the whole struct walks
    // M as the inner index and N as the outer index.
    typedef struct packed {
        n_idx_t n;
        m_idx_t m;
    } div_pair_t;

    typedef enum logic [1:0] {
        SCAN_IDLE,
        SCAN_ISSUE,
        SCAN_WAIT
    } scan_state_e;

    function automatic freq_t cand_divisor(input div_pair_t p);
        freq_t lin;
        lin = freq_t'(SCALE) * (freq_t'(p.m) + freq_t'(1));
        return lin << (freq_t'(p.n) + freq_t'(1));
    endfunction

    function automatic logic [BAUD_W-1:0] pack_baud(input div_pair_t p);
        return {p.m, p.n};
    endfunction

endpackage

// File: rtl/bsr_divider.sv
module bsr_divider #(
    parameter int W = baud_search_pkg::FREQ_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     quo_q;
    logic [W:0]       rem_q;
    logic [W-1:0]     dsr_q;

    logic [W:0]       shifted;
    logic [W+1:0]     trial;

    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        trial   = {1'b0, shifted} - {2'b00, dsr_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
        end else if (go_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(W);
            quo_q  <= dividend_i;
            rem_q  <= '0;
            dsr_q  <= divisor_i;
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                if (!trial[W+1]) begin
                    rem_q <= trial[W:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted;
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CNT_W'(1);
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    assign done_o = busy_q && (cnt_q == '0);
    assign quot_o = quo_q;

endmodule

// File: rtl/bsr_scan_ctrl.sv
module bsr_scan_ctrl
    import baud_search_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      div_done_i,
    input  logic      exact_i,
    output logic      launch_o,
    output logic      go_o,
    output logic      eval_o,
    output logic      busy_o,
    output logic      done_o,
    output div_pair_t idx_o
);
    scan_state_e state_q;
    div_pair_t   idx_q;
    logic        done_q;
    logic        last_pair;

    assign launch_o  = (state_q == SCAN_IDLE) && start_i;
    assign go_o      = (state_q == SCAN_ISSUE);
    assign eval_o    = (state_q == SCAN_WAIT) && div_done_i;
    assign last_pair = (idx_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SCAN_IDLE: begin
                    if (start_i) begin
                        idx_q   <= '0;
                        state_q <= SCAN_ISSUE;
                    end
                end
                SCAN_ISSUE: begin
                    state_q <= SCAN_WAIT;
                end
                SCAN_WAIT: begin
                    if (div_done_i) begin
                        if (exact_i || last_pair) begin
                            state_q <= SCAN_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= SCAN_ISSUE;
                        end
                    end
                end
                default: state_q <= SCAN_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != SCAN_IDLE);
    assign done_o = done_q;
    assign idx_o  = idx_q;

endmodule

// File: rtl/bsr_best_track.sv
module bsr_best_track
    import baud_search_pkg::*;
#(
    parameter int W = FREQ_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         launch_i,
    input  logic         eval_i,
    input  div_pair_t    idx_i,
    input  logic [W-1:0] cand_i,
    input  logic [W-1:0] req_i,
    output logic         exact_o,
    output logic         found_o,
    output div_pair_t    best_o
);
    logic [W-1:0] best_diff_q;
    logic [W-1:0] diff;
    logic         fits;
    logic         accept;
    logic         found_q;
    div_pair_t    best_q;

    always_comb begin
        diff    = req_i - cand_i;
        fits    = (cand_i <= req_i);
        accept  = fits && (diff < best_diff_q);
        exact_o = accept && (diff == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            best_diff_q <= '1;
            found_q     <= 1'b0;
            best_q      <= '0;
        end else if (launch_i) begin
            best_diff_q <= '1;
            found_q     <= 1'b0;
            best_q      <= '0;
        end else if (eval_i && accept) begin
            best_diff_q <= diff;
            found_q     <= 1'b1;
            best_q      <= idx_i;
        end
    end

    assign found_o = found_q;
    assign best_o  = best_q;

endmodule

// File: rtl/baud_search.sv
module baud_search
    import baud_search_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] fref_i,
    input  logic [FREQ_W-1:0] req_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              found_o,
    output logic [N_W-1:0]    n_o,
    output logic [M_W-1:0]    m_o,
    output logic [BAUD_W-1:0] baud_o
);
    logic        launch;
    logic        go;
    logic        eval;
    logic        div_done;
    logic        exact;
    freq_t       fref_q;
    freq_t       req_q;
    freq_t       quot;
    freq_t       divisor;
    div_pair_t   idx;
    div_pair_t   best;

    always_ff @(posedge clk) begin
        if (rst) begin
            fref_q <= '0;
            req_q  <= '0;
        end else if (launch) begin
            fref_q <= fref_i;
            req_q  <= req_i;
        end
    end

    assign divisor = cand_divisor(idx);

    bsr_scan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .div_done_i (div_done),
        .exact_i    (exact),
        .launch_o   (launch),
        .go_o       (go),
        .eval_o     (eval),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .idx_o      (idx)
    );

    bsr_divider #(.W(FREQ_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .go_i       (go),
        .dividend_i (fref_q),
        .divisor_i  (divisor),
        .done_o     (div_done),
        .quot_o     (quot)
    );

    bsr_best_track #(.W(FREQ_W)) u_best (
        .clk      (clk),
        .rst      (rst),
        .launch_i (launch),
        .eval_i   (eval),
        .idx_i    (idx),
        .cand_i   (quot),
        .req_i    (req_q),
        .exact_o  (exact),
        .found_o  (found_o),
        .best_o   (best)
    );

    assign n_o    = best.n;
    assign m_o    = best.m;
    assign baud_o = pack_baud(best);

endmodule

// File: rtl/baud_search_chk.sv
module baud_search_chk
    import baud_search_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              found_o,
    input logic [N_W-1:0]    n_o,
    input logic [M_W-1:0]    m_o,
    input logic [BAUD_W-1:0] baud_o
);
    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    a_r1_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r6_no_fit_zero: assert property (@(posedge clk) disable iff (rst)
        (done_o && !found_o) |-> (n_o == '0 && m_o == '0));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(baud_o) && $stable(found_o)));
endmodule

bind baud_search baud_search_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .found_o (found_o),
    .n_o     (n_o),
    .m_o     (m_o),
    .baud_o  (baud_o)
);

// File: tb/baud_search_bench.sv
`timescale 1ns/1ps
module baud_search_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] fref_i = '0;
    logic [31:0] req_i = '0;
    logic        busy_o, done_o, found_o;
    logic [2:0]  n_o;
    logic [3:0]  m_o;
    logic [6:0]  baud_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    baud_search u_baud_search (
        .clk(clk), .rst(rst), .start_i(start_i), .fref_i(fref_i), .req_i(req_i),
        .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
        .n_o(n_o), .m_o(m_o), .baud_o(baud_o)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] fref, input logic [31:0] req,
                         output logic [2:0] en, output logic [3:0] em,
                         output logic ef, output int k);
        logic [31:0] best;
        logic [31:0] cand;
        logic        stop;
        best = '1; en = 0; em = 0; ef = 0; k = 0; stop = 0;
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 16; m++) begin
                if (!stop) begin
                    k++;
                    cand = 32'(longint'(fref) / (longint'(10) * (m + 1) * (longint'(1) << (n + 1))));
                    if (cand <= req && (req - cand) < best) begin
                        best = req - cand; en = 3'(n); em = 4'(m); ef = 1;
                    end
                    if (best == 0) stop = 1;
                end
            end
        end
    endtask

    task automatic run_one(input logic [31:0] fref, input logic [31:0] req, input logic glitch);
        logic [2:0] en; logic [3:0] em; logic ef; int k; int cnt;
        logic [6:0] held;
        model(fref, req, en, em, ef, k);
        @(negedge clk);
        fref_i = fref; req_i = req; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R1 busy after start", busy_o, 1);
        cnt = 0;
        while (1) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (glitch && cnt == 40) begin
                start_i = 1'b1; fref_i = 32'd7; req_i = 32'd123456;
            end else if (glitch && cnt == 41) begin
                start_i = 1'b0;
            end
            if (done_o === 1'b1 || cnt > 5000) break;
        end
        check(cnt == 34 * k, glitch ? "R8 latency with ignored start" : "R4 done latency", cnt, 34 * k);
        check(n_o == en, glitch ? "R8 N result" : "R3 N result", n_o, en);
        check(m_o == em, glitch ? "R8 M result" : "R3 M result", m_o, em);
        check(found_o == ef, "R6 found flag", found_o, ef);
        check(baud_o == {em, en}, "R7 packed value", baud_o, {em, en});
        check(busy_o === 1'b0, "R5 busy low at done", busy_o, 0);
        held = baud_o;
        fref_i = 32'hDEAD_BEEF; req_i = 32'd5;
        @(negedge clk);
        check(done_o === 1'b0, "R5 done single cycle", done_o, 0);
        repeat (3) @(negedge clk);
        check(baud_o == held && found_o == ef, "R9 outputs held", baud_o, held);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0, "R5 reset idle", busy_o, 0);
        check(found_o === 1'b0 && baud_o === 7'd0, "R6 reset outputs", baud_o, 0);

        // R2 R4 exact hit on the first pair: 200/20 = 10
        run_one(32'd200, 32'd10, 1'b0);
        // R6 nothing fits: smallest rate is 10e6/40960 = 244
        run_one(32'd10_000_000, 32'd100, 1'b0);
        // R3 typical settings
        run_one(32'd166_666_667, 32'd100_000, 1'b0);
        run_one(32'd250_000_000, 32'd400_000, 1'b0);
        run_one(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        // R8 start in mid search is ignored
        run_one(32'd200_000_000, 32'd100_000, 1'b1);
        // R2 R3 sweep of requests against a small reference
        for (int i = 0; i <= 12; i++) begin
            run_one(32'd48_000, 32'(i * 200), 1'b0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule